// File: doc/BRIEF.md
# Security-Tagged Cache Tag Array

This block holds the tag side of a small, physically tagged, set-associative data cache. Each line records the physical address space it belongs to: Secure or Non-secure. That bit is compared on every lookup as if it were one more address bit, so the same numeric address in the two spaces occupies two independent lines. Read and write accesses look the tag store up and allocate on a miss. Allocation prefers an empty way and otherwise takes the tree pseudo-LRU victim. A dirty victim is handed out as a writeback request before the access completes.

Maintenance commands are invalidate, clean, and clean-and-invalidate. Each comes in two forms. The by-address form targets the line whose tag and address-space bit both match the request. The by-set/way form names a set and a way directly. For the set/way form, the issuer's security state filters what may be touched: a Non-secure issuer can only reach Non-secure lines. Only a Secure issuer can therefore empty or clean the whole cache.

One request is accepted per cycle while `req_ready` is high. Each accepted request produces exactly one `resp_valid` pulse, which carries a hit/acted flag and a way number.

Top module: `sectag_cache`

## Requirements
- R1: A synchronous reset clears every valid and dirty bit in a single cycle. After reset `req_ready` is 1, `resp_valid` and `wb_req` are 0, and any lookup misses.
- R2: A read (cmd 0) or write (cmd 1) that needs no writeback raises `resp_valid` for one cycle, on the cycle after acceptance. `resp_hit` is 1 only when a valid line matches the address tag, the set and `req_ns`, and `resp_way` gives the way that was hit or filled. Address bits [5:0] are the byte offset, [11:6] the set, and [31:12] the tag.
- R3: `req_ns` (1 = Non-secure space, 0 = Secure space) is part of the tag compare. Secure and Non-secure lines with the same numeric address coexist in one set and never hit each other.
- R4: On a miss, the line goes into the lowest-numbered invalid way. If no way is invalid, it goes into the way chosen by the tree pseudo-LRU. Read and write hits and fills update the tree; maintenance leaves it untouched.
- R5: A write marks the line dirty, whether it hits or allocates. A read fill allocates the line clean.
- R6: A fill that evicts a valid dirty line raises `wb_req` with the victim's line address (offset zero) and its space bit. `resp_valid` follows only after `wb_ack`.
- R7: By-address maintenance (cmd 2 invalidate, 3 clean, 4 clean-and-invalidate) acts only on the line matching the address and `req_ns`, whatever `req_issuer_ns` is. `resp_hit` reports whether a line matched.
- R8: Set/way maintenance (cmd 5 invalidate, 6 clean, 7 clean-and-invalidate) issued with `req_issuer_ns`=1 acts only on a Non-secure line. When it targets a Secure line, the command completes with `resp_hit`=0 and changes nothing.
- R9: Set/way maintenance issued with `req_issuer_ns`=0 acts on the selected line in either space.
- R10: Clean or clean-and-invalidate on a valid dirty line gives a one-cycle `wb_req` carrying the full line address and space bit, and completes after `wb_ack`. Clean keeps the line valid and clean. Invalidate drops a dirty line without any writeback.
- R11: `req_ready` stays low from the acceptance of a command that needs a writeback until `wb_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_cmd | input | 3 | Command code (0..7, see requirements) |
| req_addr | input | 32 | Physical byte address for access and by-address commands |
| req_ns | input | 1 | Address space of `req_addr`, 1 = Non-secure |
| req_issuer_ns | input | 1 | Security state of the issuer, 1 = Non-secure |
| req_set | input | 6 | Set index for set/way commands |
| req_way | input | 2 | Way index for set/way commands |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Hit (access) or line acted on (maintenance) |
| resp_way | output | 2 | Way hit, filled or targeted |
| wb_req | output | 1 | One-cycle writeback request |
| wb_addr | output | 32 | Line address to write back |
| wb_ns | output | 1 | Address space of the line to write back |
| wb_ack | input | 1 | Writeback accepted |

## Verification
The bench builds the block with its default geometry: 4 ways, 64 sets, 64-byte lines and a 32-bit address. With four ways, a set fills after four allocations, so the pseudo-LRU tree is small enough to predict by hand. This makes both the replacement order and a dirty-victim eviction reachable with a handful of accesses. Two sets are exercised. In one, Secure and Non-secure copies of the same address share the set, and maintenance is issued from both security states against the same set/way. The other is driven through full-set replacement.

// File: rtl/sectag_pkg.sv
package sectag_pkg;

  typedef enum logic [2:0] {
    CMD_READ    = 3'd0,
    CMD_WRITE   = 3'd1,
    CMD_INV_PA  = 3'd2,
    CMD_CLN_PA  = 3'd3,
    CMD_CIV_PA  = 3'd4,
    CMD_INV_SW  = 3'd5,
    CMD_CLN_SW  = 3'd6,
    CMD_CIV_SW  = 3'd7
  } cmd_e;

  function automatic logic cmd_is_access(input cmd_e c);
    return (c == CMD_READ) || (c == CMD_WRITE);
  endfunction

  function automatic logic cmd_is_setway(input cmd_e c);
    return (c == CMD_INV_SW) || (c == CMD_CLN_SW) || (c == CMD_CIV_SW);
  endfunction

  // clean or clean-and-invalidate: dirty data must leave the cache
  function automatic logic cmd_cleans(input cmd_e c);
    return (c == CMD_CLN_PA) || (c == CMD_CIV_PA) ||
           (c == CMD_CLN_SW) || (c == CMD_CIV_SW);
  endfunction

  // only a plain clean leaves the line resident
  function automatic logic cmd_keeps_line(input cmd_e c);
    return (c == CMD_CLN_PA) || (c == CMD_CLN_SW);
  endfunction

  function automatic logic cmd_is_inval_only(input cmd_e c);
    return (c == CMD_INV_PA) || (c == CMD_INV_SW);
  endfunction

endpackage

// File: rtl/sectag_plru.sv
module sectag_plru #(
  parameter int SETS = 64,
  parameter int WAYS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(SETS)-1:0]    rd_set,
  output logic [$clog2(WAYS)-1:0]    victim,
  input  logic                       upd_en,
  input  logic [$clog2(SETS)-1:0]    upd_set,
  input  logic [$clog2(WAYS)-1:0]    upd_way
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  // heap-ordered tree, node n stored at bit n-1; a 1 steers toward the right child
  logic [NODES-1:0] tree_q [SETS];

  function automatic logic [WAY_W-1:0] tree_walk(input logic [NODES-1:0] t);
    int n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + (t[n-1] ? 1 : 0);
    return WAY_W'(n - WAYS);
  endfunction

  function automatic logic [NODES-1:0] tree_touch(input logic [NODES-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    int n;
    int p;
    r = t;
    n = int'(w) + WAYS;
    for (int l = 0; l < WAY_W; l++) begin
      p = n / 2;
      r[p-1] = ((n % 2) == 0);  // point away from the used child
      n = p;
    end
    return r;
  endfunction

  assign victim = tree_walk(tree_q[rd_set]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en) begin
      tree_q[upd_set] <= tree_touch(tree_q[upd_set], upd_way);
    end
  end

  // the way just used is never the next victim of its set
  assert_touched_not_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (upd_set == rd_set)) |=> ((rd_set != $past(upd_set)) || (victim != $past(upd_way))));

endmodule

// File: rtl/sectag_store.sv
module sectag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   rd_set,
  input  logic [TAG_W-1:0]          cmp_tag,
  input  logic                      cmp_ns,
  output logic [WAYS-1:0]           way_valid,
  output logic [WAYS-1:0]           way_dirty,
  output logic [WAYS-1:0]           way_ns,
  output logic [TAG_W-1:0]          way_tag [WAYS],
  output logic [WAYS-1:0]           hit_vec,
  input  logic                      wr_en,
  input  logic [$clog2(SETS)-1:0]   wr_set,
  input  logic [$clog2(WAYS)-1:0]   wr_way,
  input  logic                      wr_valid,
  input  logic                      wr_dirty,
  input  logic                      wr_ns,
  input  logic [TAG_W-1:0]          wr_tag
);
  logic [WAYS-1:0]  vld_q   [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  ns_q    [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  assign way_valid = vld_q[rd_set];
  assign way_dirty = dirty_q[rd_set];
  assign way_ns    = ns_q[rd_set];

  // space bit compared like one more tag bit
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_tag[w] = tag_q[rd_set][w];
    assign hit_vec[w] = way_valid[w] && (way_ns[w] == cmp_ns) && (way_tag[w] == cmp_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]   <= '0;
        dirty_q[s] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_set][wr_way]   <= wr_valid;
      dirty_q[wr_set][wr_way] <= wr_valid && wr_dirty;
      ns_q[wr_set][wr_way]    <= wr_ns;
      tag_q[wr_set][wr_way]   <= wr_tag;
    end
  end

  // allocation never creates a second copy of one (space, tag)
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // a dirty bit never stands on an invalid line
  assert_dirty_implies_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((way_dirty & ~way_valid) == '0));

endmodule

// File: rtl/sectag_cache.sv
module sectag_cache
  import sectag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [2:0]                req_cmd,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_ns,
  input  logic                      req_issuer_ns,
  input  logic [$clog2(SETS)-1:0]   req_set,
  input  logic [$clog2(WAYS)-1:0]   req_way,
  output logic                      resp_valid,
  output logic                      resp_hit,
  output logic [$clog2(WAYS)-1:0]   resp_way,
  output logic                      wb_req,
  output logic [ADDR_W-1:0]         wb_addr,
  output logic                      wb_ns,
  input  logic                      wb_ack
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  typedef enum logic {ST_IDLE, ST_WB} state_e;

  function automatic logic [IDX_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                 input logic [IDX_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [WAY_W-1:0] onehot_index(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] lowest_zero(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (!v[w]) r = WAY_W'(w);
    return r;
  endfunction

  // ---------------- request decode ----------------
  cmd_e             cmd;
  logic             accept;
  logic             is_acc, is_sw, is_maint;
  logic [IDX_W-1:0] sel_set;
  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] offset_unused;

  assign cmd           = cmd_e'(req_cmd);
  assign is_acc        = cmd_is_access(cmd);
  assign is_sw         = cmd_is_setway(cmd);
  assign is_maint      = !is_acc;
  assign sel_set       = is_sw ? req_set : addr_set(req_addr);
  assign req_tag       = addr_tag(req_addr);
  assign offset_unused = req_addr[OFF_W-1:0];

  // ---------------- storage ----------------
  logic [WAYS-1:0]  way_valid, way_dirty, way_ns, hit_vec;
  logic [TAG_W-1:0] way_tag [WAYS];
  logic             wr_en, wr_valid, wr_dirty, wr_ns;
  logic [TAG_W-1:0] wr_tag;
  logic [WAY_W-1:0] victim;
  logic             plru_en;

  sectag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .rd_set(sel_set), .cmp_tag(req_tag), .cmp_ns(req_ns),
    .way_valid(way_valid), .way_dirty(way_dirty), .way_ns(way_ns),
    .way_tag(way_tag), .hit_vec(hit_vec),
    .wr_en(wr_en), .wr_set(sel_set), .wr_way(tgt_way),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty), .wr_ns(wr_ns), .wr_tag(wr_tag)
  );

  // ---------------- lookup and target selection ----------------
  logic             lk_hit, has_free;
  logic [WAY_W-1:0] lk_way, free_way, alloc_way, tgt_way;
  logic             tgt_valid, tgt_dirty, tgt_ns;
  logic [TAG_W-1:0] tgt_tag;
  logic             sw_allowed, acted, need_wb, rsp_hit_d;

  assign lk_hit    = |hit_vec;
  assign lk_way    = onehot_index(hit_vec);
  assign has_free  = ~&way_valid;
  assign free_way  = lowest_zero(way_valid);
  assign alloc_way = has_free ? free_way : victim;

  always_comb begin
    if (is_sw)                 tgt_way = req_way;
    else if (is_acc && !lk_hit) tgt_way = alloc_way;
    else                       tgt_way = lk_way;
  end

  assign tgt_valid = way_valid[tgt_way];
  assign tgt_dirty = way_dirty[tgt_way];
  assign tgt_ns    = way_ns[tgt_way];
  assign tgt_tag   = way_tag[tgt_way];

  // Non-secure issuer may only reach Non-secure lines by set/way
  assign sw_allowed = tgt_valid && (!req_issuer_ns || tgt_ns);
  assign acted      = is_acc ? 1'b1 : (is_sw ? sw_allowed : lk_hit);
  assign rsp_hit_d  = is_acc ? lk_hit : acted;

  assign need_wb = accept && tgt_valid && tgt_dirty &&
                   ((is_acc && !lk_hit) || (is_maint && acted && cmd_cleans(cmd)));

  sectag_plru #(.SETS(SETS), .WAYS(WAYS)) plru_i (
    .clk(clk), .rst_n(rst_n),
    .rd_set(sel_set), .victim(victim),
    .upd_en(plru_en), .upd_set(sel_set), .upd_way(tgt_way)
  );

  // ---------------- entry update ----------------
  always_comb begin
    wr_en    = accept && acted;
    plru_en  = accept && is_acc;
    if (is_acc) begin
      wr_valid = 1'b1;
      wr_dirty = (cmd == CMD_WRITE) || (lk_hit && tgt_dirty);
      wr_ns    = req_ns;
      wr_tag   = req_tag;
    end else begin
      wr_valid = cmd_keeps_line(cmd);
      wr_dirty = 1'b0;
      wr_ns    = tgt_ns;
      wr_tag   = tgt_tag;
    end
  end

  // ---------------- control ----------------
  state_e           state_q;
  logic             resp_valid_q, resp_hit_q, wb_req_q, wb_ns_q;
  logic [WAY_W-1:0] resp_way_q;
  logic [ADDR_W-1:0] wb_addr_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign resp_way   = resp_way_q;
  assign wb_req     = wb_req_q;
  assign wb_addr    = wb_addr_q;
  assign wb_ns      = wb_ns_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_way_q   <= '0;
      wb_req_q     <= 1'b0;
      wb_addr_q    <= '0;
      wb_ns_q      <= 1'b0;
    end else begin
      resp_valid_q <= 1'b0;
      wb_req_q     <= 1'b0;
      if (accept) begin
        resp_hit_q <= rsp_hit_d;
        resp_way_q <= tgt_way;
        if (need_wb) begin
          state_q   <= ST_WB;
          wb_req_q  <= 1'b1;
          wb_addr_q <= line_addr(tgt_tag, sel_set);
          wb_ns_q   <= tgt_ns;
        end else begin
          resp_valid_q <= 1'b1;
        end
      end else if (state_q == ST_WB && wb_ack) begin
        state_q      <= ST_IDLE;
        resp_valid_q <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_wb_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> !wb_req);

  assert_busy_during_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !req_ready);

  assert_hold_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !wb_ack) |=> (!req_ready && !resp_valid));

  assert_resp_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && wb_ack) |=> (resp_valid && req_ready));

  assert_ns_setway_filtered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_sw && req_issuer_ns && tgt_valid && !tgt_ns)
      |=> (resp_valid && !resp_hit && !wb_req));

  assert_inval_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_is_inval_only(cmd)) |=> (resp_valid && !wb_req));

  assert_no_fill_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_acc && lk_hit) |=> (resp_valid && resp_hit && !wb_req));

endmodule

// File: tb/sectag_cache_tb_top.sv
module sectag_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_cmd;
  logic [31:0] req_addr;
  logic        req_ns;
  logic        req_issuer_ns;
  logic [5:0]  req_set;
  logic [1:0]  req_way;
  logic        resp_valid;
  logic        resp_hit;
  logic [1:0]  resp_way;
  logic        wb_req;
  logic [31:0] wb_addr;
  logic        wb_ns;
  logic        wb_ack;

  always #4 clk = ~clk;  // 125 MHz

  sectag_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_ns(req_ns), .req_issuer_ns(req_issuer_ns),
    .req_set(req_set), .req_way(req_way),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ns(wb_ns), .wb_ack(wb_ack)
  );

  localparam logic [2:0] RD = 3'd0, WR = 3'd1, INVA = 3'd2, CLNA = 3'd3,
                         CIVA = 3'd4, INVS = 3'd5, CLNS = 3'd6, CIVS = 3'd7;
  localparam logic SEC = 1'b0, NSEC = 1'b1;

  typedef struct { logic hit; logic [1:0] way; logic chk_way; string rq; } exp_resp_t;
  typedef struct { logic [31:0] addr; logic ns; string rq; } exp_wb_t;

  exp_resp_t resp_q[$];
  exp_wb_t   wb_q[$];

  int drv_checks = 0, drv_fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int cycles = 0;

  function automatic logic [31:0] mk_addr(input logic [19:0] tag, input logic [5:0] st,
                                          input logic [5:0] off);
    return {tag, st, off};
  endfunction

  task automatic dchk(input logic ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    drv_checks++;
    if (!ok) begin
      drv_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", (drv_checks + mon_checks) - (drv_fails + mon_fails),
             drv_checks + mon_checks);
    $finish;
  endtask

  // monitor: completions, writeback requests, watchdog
  always @(negedge clk) begin
    cycles++;
    wb_ack <= 1'b0;
    if (rst_n && resp_valid) begin
      mon_checks++;
      if (resp_q.size() == 0) begin
        mon_fails++;
        $display("FAIL R2 unexpected completion: actual hit=%0d expected none", resp_hit);
      end else begin
        exp_resp_t e;
        e = resp_q.pop_front();
        if (resp_hit !== e.hit || (e.chk_way && resp_way !== e.way)) begin
          mon_fails++;
          $display("FAIL %s completion: actual hit=%0d way=%0d expected hit=%0d way=%0d",
                   e.rq, resp_hit, resp_way, e.hit, e.way);
        end
      end
    end
    if (rst_n && wb_req) begin
      mon_checks++;
      if (req_ready !== 1'b0) begin
        mon_fails++;
        $display("FAIL R11 ready during writeback: actual %0d expected 0", req_ready);
      end
      mon_checks++;
      if (wb_q.size() == 0) begin
        mon_fails++;
        $display("FAIL R10 unexpected writeback: actual addr=%0h ns=%0d expected none",
                 wb_addr, wb_ns);
      end else begin
        exp_wb_t w;
        w = wb_q.pop_front();
        if (wb_addr !== w.addr || wb_ns !== w.ns) begin
          mon_fails++;
          $display("FAIL %s writeback: actual addr=%0h ns=%0d expected addr=%0h ns=%0d",
                   w.rq, wb_addr, wb_ns, w.addr, w.ns);
        end
      end
      wb_ack <= 1'b1;
    end
    if (cycles > 20000) begin
      mon_checks++;
      mon_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  // driver: queue the expectation, present one command, wait for its completion
  task automatic op(input logic [2:0] c, input logic [19:0] tag, input logic [5:0] st,
                    input logic ns, input logic iss_ns, input logic [1:0] sw_way,
                    input logic exp_hit, input logic [1:0] exp_way, input logic chk_way,
                    input string rq);
    exp_resp_t e;
    logic expect_wb;
    e.hit = exp_hit; e.way = exp_way; e.chk_way = chk_way; e.rq = rq;
    resp_q.push_back(e);
    expect_wb = (wb_q.size() != 0);
    while (!req_ready) @(negedge clk);
    req_valid     = 1'b1;
    req_cmd       = c;
    req_addr      = mk_addr(tag, st, 6'h2c);
    req_ns        = ns;
    req_issuer_ns = iss_ns;
    req_set       = st;
    req_way       = sw_way;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!expect_wb) dchk(resp_valid === 1'b1, rq, "completion one cycle after accept",
                         32'(resp_valid), 32'd1);
    while (resp_q.size() != 0) @(negedge clk);
  endtask

  task automatic want_wb(input logic [19:0] tag, input logic [5:0] st, input logic ns,
                         input string rq);
    exp_wb_t w;
    w.addr = mk_addr(tag, st, 6'h00); w.ns = ns; w.rq = rq;
    wb_q.push_back(w);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    dchk(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
    dchk(resp_valid === 1'b0, "R1", "no completion after reset", 32'(resp_valid), 32'd0);
    dchk(wb_req === 1'b0, "R1", "no writeback after reset", 32'(wb_req), 32'd0);
  endtask

  localparam logic [19:0] TA = 20'h00a11, TB = 20'h00b22;

  initial begin
    req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_ns = 1'b0;
    req_issuer_ns = 1'b0; req_set = '0; req_way = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();

    // R2 R4: first fill, then hit
    op(RD, TA, 6'd5, SEC,  SEC, 2'd0, 1'b0, 2'd0, 1'b1, "R2 R4 fill S:A");
    op(RD, TA, 6'd5, SEC,  SEC, 2'd0, 1'b1, 2'd0, 1'b1, "R2 hit S:A");
    // R3: the same numeric address in the other space is a different line
    op(RD, TA, 6'd5, NSEC, SEC, 2'd0, 1'b0, 2'd1, 1'b1, "R3 fill N:A");
    op(RD, TA, 6'd5, SEC,  SEC, 2'd0, 1'b1, 2'd0, 1'b1, "R3 S:A still way0");
    op(RD, TA, 6'd5, NSEC, SEC, 2'd0, 1'b1, 2'd1, 1'b1, "R3 N:A way1");
    // R5 then R10 R7: clean by address from a Secure issuer writes back the NS line
    op(WR, TA, 6'd5, NSEC, SEC, 2'd0, 1'b1, 2'd1, 1'b1, "R5 write N:A");
    want_wb(TA, 6'd5, NSEC, "R10 clean N:A");
    op(CLNA, TA, 6'd5, NSEC, SEC, 2'd0, 1'b1, 2'd1, 1'b1, "R10 R7 clean N:A");
    op(CLNA, TA, 6'd5, NSEC, NSEC, 2'd0, 1'b1, 2'd1, 1'b1, "R10 second clean no wb");
    op(RD, TA, 6'd5, NSEC, SEC, 2'd0, 1'b1, 2'd1, 1'b1, "R10 clean keeps line");
    // R7: by-address from NS issuer reaches Secure line, leaves NS copy
    op(INVA, TA, 6'd5, SEC, NSEC, 2'd0, 1'b1, 2'd0, 1'b1, "R7 inval S:A");
    op(RD, TA, 6'd5, NSEC, SEC, 2'd0, 1'b1, 2'd1, 1'b1, "R7 N:A untouched");
    op(RD, TA, 6'd5, SEC,  SEC, 2'd0, 1'b0, 2'd0, 1'b1, "R7 S:A refills way0");
    op(INVA, TB, 6'd5, NSEC, SEC, 2'd0, 1'b0, 2'd0, 1'b0, "R7 absent line");
    // R8: Non-secure set/way cannot reach the Secure dirty line
    op(WR, TA, 6'd5, SEC, SEC, 2'd0, 1'b1, 2'd0, 1'b1, "R5 write S:A");
    op(INVS, TA, 6'd5, SEC, NSEC, 2'd0, 1'b0, 2'd0, 1'b1, "R8 NS inval s/w filtered");
    op(CIVS, TA, 6'd5, SEC, NSEC, 2'd0, 1'b0, 2'd0, 1'b1, "R8 NS clean-inv s/w filtered");
    op(RD, TA, 6'd5, SEC, SEC, 2'd0, 1'b1, 2'd0, 1'b1, "R8 S:A still present");
    // R9: Secure set/way reaches it, dirty data leaves
    want_wb(TA, 6'd5, SEC, "R9 R10 clean-inv S:A");
    op(CIVS, TA, 6'd5, SEC, SEC, 2'd0, 1'b1, 2'd0, 1'b1, "R9 S clean-inv s/w");
    op(RD, TA, 6'd5, SEC, SEC, 2'd0, 1'b0, 2'd0, 1'b1, "R9 S:A gone");
    // R8: Non-secure set/way does act on a Non-secure line
    op(INVS, TA, 6'd5, SEC, NSEC, 2'd1, 1'b1, 2'd1, 1'b1, "R8 NS inval NS line");
    op(RD, TA, 6'd5, NSEC, SEC, 2'd0, 1'b0, 2'd1, 1'b1, "R8 N:A gone");
    // R10 R5: invalidate drops dirty data silently; read fill is clean
    op(WR, TB, 6'd5, NSEC, SEC, 2'd0, 1'b0, 2'd2, 1'b1, "R5 write-allocate N:B");
    op(INVA, TB, 6'd5, NSEC, SEC, 2'd0, 1'b1, 2'd2, 1'b1, "R10 inval dirty no wb");
    op(RD, TB, 6'd5, NSEC, SEC, 2'd0, 1'b0, 2'd2, 1'b1, "R5 read fill N:B");
    op(CLNA, TB, 6'd5, NSEC, SEC, 2'd0, 1'b1, 2'd2, 1'b1, "R5 clean of clean line");

    // R4: replacement order in set 0
    for (int i = 0; i < 4; i++)
      op(RD, 20'h10 + 20'(i), 6'd0, SEC, SEC, 2'd0, 1'b0, 2'(i), 1'b1, "R4 fill free way");
    op(RD, 20'h14, 6'd0, SEC, SEC, 2'd0, 1'b0, 2'd0, 1'b1, "R4 plru victim way0");
    op(RD, 20'h11, 6'd0, SEC, SEC, 2'd0, 1'b1, 2'd1, 1'b1, "R4 hit way1");
    op(RD, 20'h15, 6'd0, SEC, SEC, 2'd0, 1'b0, 2'd2, 1'b1, "R4 plru victim way2");
    // R6: make dirty way0 least recent, then evict it
    op(WR, 20'h14, 6'd0, SEC, SEC, 2'd0, 1'b1, 2'd0, 1'b1, "R6 dirty way0");
    op(RD, 20'h11, 6'd0, SEC, SEC, 2'd0, 1'b1, 2'd1, 1'b1, "R6 touch way1");
    op(RD, 20'h15, 6'd0, SEC, SEC, 2'd0, 1'b1, 2'd2, 1'b1, "R6 touch way2");
    op(RD, 20'h13, 6'd0, SEC, SEC, 2'd0, 1'b1, 2'd3, 1'b1, "R6 touch way3");
    want_wb(20'h14, 6'd0, SEC, "R6 evict dirty");
    op(RD, 20'h16, 6'd0, SEC, SEC, 2'd0, 1'b0, 2'd0, 1'b1, "R6 fill after writeback");

    // R1: reset mid-run empties the cache
    do_reset();
    op(RD, 20'h11, 6'd0, SEC,  SEC, 2'd0, 1'b0, 2'd0, 1'b1, "R1 miss after reset");
    op(RD, TA,     6'd5, NSEC, SEC, 2'd0, 1'b0, 2'd0, 1'b1, "R1 miss after reset NS");

    repeat (3) @(negedge clk);
    dchk(resp_q.size() == 0 && wb_q.size() == 0, "R2", "outstanding expectations",
         32'(resp_q.size() + wb_q.size()), 32'd0);
    summary();
  end
endmodule